// File: doc/BRIEF.md
# Tristate Phase-Frequency Detector with Error Integrator

This block is the phase-frequency comparison stage of a cycle-based digital model of an integer-N frequency synthesizer. It runs on a fast system clock and receives two oversampled square waves: the reference and the divided-down feedback from the oscillator. Each input passes through a synchronizer and a rising-edge detector. The edges then drive a four-state machine. An edge on the reference raises the `up` request. An edge on the feedback raises the `dn` request. When both requests are up at once, they are dropped together.

The result is a three-level signed error: +1, 0 or -1. Its average over many cycles changes linearly across a phase span of four times pi. Its sign also follows the sign of any frequency offset, so a loop built around it always pulls back into lock. An on-board saturating accumulator sums the error code on every clock. Clearing it and reading it after a window gives the average characteristic without any external filter.

The states are:
- ST_IDLE: no request.
- ST_UP: the reference led.
- ST_DN: the feedback led.
- ST_BOTH: a single overlap cycle.

The transitions are:
- IDLE->UP on a lone reference edge.
- IDLE->DN on a lone feedback edge.
- IDLE->IDLE when both edges land in the same cycle.
- UP->BOTH on a feedback edge.
- DN->BOTH on a reference edge.
- BOTH->IDLE always.

Top module: `pfd_tristate`

## Requirements
- R1: While reset is asserted and right after it is released, `up`, `dn`, `err` and `acc` are all zero.
- R2: A rising level on `ref_in`, first sampled high at clock edge k, sets `up` after clock edge k+2, provided the machine is idle or already holds `dn` alone.
- R3: A rising level on `fb_in`, first sampled high at clock edge k, sets `dn` after clock edge k+2, provided the machine is idle or already holds `up` alone.
- R4: Once a request is set, further rising edges on the same input do not change `up` or `dn`.
- R5: When both requests are high, they stay high together for exactly one cycle and are then both cleared. Edges detected during that overlap cycle are discarded.
- R6: If rising edges of both inputs are detected in the same cycle while idle, neither request is set.
- R7: `err` is 2-bit two's complement. It is 2'b01 (+1) when only `up` is high, 2'b11 (-1) when only `dn` is high, and 2'b00 otherwise, including the overlap cycle.
- R8: On each clock edge, `acc` becomes `acc + err` of the cycle before that edge. When `acc_clr` is high at that edge, `acc` becomes zero instead, taking priority over the addition.
- R9: `acc` is signed two's complement and saturates at 2^(ACC_W-1)-1 and -2^(ACC_W-1) instead of wrapping.
- R10: When the reference has a higher frequency than the feedback, `acc` summed over a long window is positive. When the feedback has the higher frequency, the sum is negative.
- R11: Falling edges and steady levels on either input never set a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples both inputs |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_in | input | 1 | Reference square wave, asynchronous |
| fb_in | input | 1 | Divided feedback square wave, asynchronous |
| acc_clr | input | 1 | Synchronous clear of the error accumulator |
| up | output | 1 | Request to raise oscillator frequency |
| dn | output | 1 | Request to lower oscillator frequency |
| err | output | 2 | Signed error code: +1, 0 or -1 |
| acc | output | ACC_W | Saturating signed sum of `err` |

## Verification
The bench targets these corner cases:
- Edges of both inputs landing in the same detection cycle. A design that let one input win would leave a stray request that drifts the accumulator.
- A new edge arriving during the overlap cycle. A design that honoured it would set a request that should have been discarded, shifting the average characteristic.
- Held levels and falling edges. A level-sensitive design would keep re-arming requests.
- Accumulator runs long enough to reach both rails. A wrapping adder would jump sign.
- Reference and feedback clocks at different rates. A plain phase detector would average near zero there instead of keeping the sign of the offset.

// File: rtl/pfd_pkg.sv
package pfd_pkg;

    typedef enum logic [1:0] {
        ST_IDLE = 2'b00,
        ST_UP   = 2'b01,
        ST_DN   = 2'b10,
        ST_BOTH = 2'b11
    } pfd_state_e;

    localparam logic [1:0] ERR_ZERO = 2'b00;
    localparam logic [1:0] ERR_POS  = 2'b01;
    localparam logic [1:0] ERR_NEG  = 2'b11;

endpackage

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sig_in,
    output logic rise
);
    localparam int LAST = STAGES - 1;

    logic [STAGES-1:0] chain;
    logic              prev_q;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[0] <= 1'b0;
                else        chain[0] <= sig_in;
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) chain[i] <= 1'b0;
                else        chain[i] <= chain[i-1];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= chain[LAST];
    end

    assign rise = chain[LAST] & ~prev_q;

    // R11
    rise_needs_low_then_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rise |=> !rise);

endmodule

// File: rtl/pfd_flag_fsm.sv
module pfd_flag_fsm
    import pfd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ref_rise,
    input  logic       fb_rise,
    output logic       up,
    output logic       dn,
    output logic [1:0] err
);
    pfd_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ref_rise && !fb_rise)      state_d = ST_UP;
                else if (fb_rise && !ref_rise) state_d = ST_DN;
                else                           state_d = ST_IDLE;
            end
            ST_UP:   if (fb_rise)  state_d = ST_BOTH;
            ST_DN:   if (ref_rise) state_d = ST_BOTH;
            ST_BOTH: state_d = ST_IDLE;
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        up  = 1'b0;
        dn  = 1'b0;
        err = ERR_ZERO;
        unique case (state_q)
            ST_IDLE: ;
            ST_UP:   begin up = 1'b1; err = ERR_POS; end
            ST_DN:   begin dn = 1'b1; err = ERR_NEG; end
            ST_BOTH: begin up = 1'b1; dn = 1'b1; end
            default: ;
        endcase
    end

    // R2
    up_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!up && !dn && ref_rise && !fb_rise) |=> (up && !dn));

    // R3
    dn_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!up && !dn && fb_rise && !ref_rise) |=> (dn && !up));

    // R4
    up_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up && !dn && !fb_rise) |=> (up && !dn));

    // R5
    joint_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (up && dn) |=> (!up && !dn));

    // R6
    tie_no_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!up && !dn && ref_rise && fb_rise) |=> (!up && !dn));

    // R7
    err_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (err == ERR_POS) == (up && !dn) && (err == ERR_NEG) == (dn && !up));

endmodule

// File: rtl/pfd_err_accum.sv
module pfd_err_accum #(
    parameter int ACC_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic [1:0]       err,
    output logic [ACC_W-1:0] acc
);
    localparam logic signed [ACC_W:0] SUM_MAX = (ACC_W+1)'(2**(ACC_W-1) - 1);
    localparam logic signed [ACC_W:0] SUM_MIN = -SUM_MAX - 1;
    localparam logic [ACC_W-1:0] ACC_MAX = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] ACC_MIN = {1'b1, {(ACC_W-1){1'b0}}};

    logic signed [ACC_W:0] sum;
    logic [ACC_W-1:0]      acc_d;

    assign sum = $signed({acc[ACC_W-1], acc}) + $signed({{(ACC_W-1){err[1]}}, err});

    always_comb begin
        if (clr)                acc_d = '0;
        else if (sum > SUM_MAX) acc_d = ACC_MAX;
        else if (sum < SUM_MIN) acc_d = ACC_MIN;
        else                    acc_d = sum[ACC_W-1:0];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) acc <= '0;
        else        acc <= acc_d;
    end

    // R8
    acc_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (acc == '0));

    // R9
    acc_top_rail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && acc == ACC_MAX && err == 2'b01) |=> (acc == ACC_MAX));

    // R9
    acc_bottom_rail_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!clr && acc == ACC_MIN && err == 2'b11) |=> (acc == ACC_MIN));

endmodule

// File: rtl/pfd_tristate.sv
module pfd_tristate #(
    parameter int SYNC_STAGES = 2,
    parameter int ACC_W       = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_in,
    input  logic             fb_in,
    input  logic             acc_clr,
    output logic             up,
    output logic             dn,
    output logic [1:0]       err,
    output logic [ACC_W-1:0] acc
);
    logic ref_rise;
    logic fb_rise;

    pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_ref_edge (
        .clk(clk), .rst_n(rst_n), .sig_in(ref_in), .rise(ref_rise));

    pfd_edge_sync #(.STAGES(SYNC_STAGES)) u_fb_edge (
        .clk(clk), .rst_n(rst_n), .sig_in(fb_in), .rise(fb_rise));

    pfd_flag_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .ref_rise(ref_rise), .fb_rise(fb_rise),
        .up(up), .dn(dn), .err(err));

    pfd_err_accum #(.ACC_W(ACC_W)) u_acc (
        .clk(clk), .rst_n(rst_n), .clr(acc_clr), .err(err), .acc(acc));

endmodule

// File: tb/pfd_tristate_tb.sv
module pfd_tristate_tb;
    localparam int ACC_W = 16;
    localparam longint AMAX = (64'sd1 <<< (ACC_W-1)) - 1;
    localparam longint AMIN = -(64'sd1 <<< (ACC_W-1));

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ref_in = 1'b0, fb_in = 1'b0, acc_clr = 1'b0;
    logic up, dn;
    logic [1:0] err;
    logic [ACC_W-1:0] acc;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    pfd_tristate #(.SYNC_STAGES(2), .ACC_W(ACC_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .ref_in(ref_in), .fb_in(fb_in),
        .acc_clr(acc_clr), .up(up), .dn(dn), .err(err), .acc(acc));

    // Reference model built from the requirements: 0 idle, 1 up, 2 dn, 3 both
    logic [2:0] mr, mf;
    int ms;
    longint macc;

    function automatic int next_st(int s, bit r, bit f);
        case (s)
            0: return (r && !f) ? 1 : ((f && !r) ? 2 : 0);
            1: return f ? 3 : 1;
            2: return r ? 3 : 2;
            default: return 0;
        endcase
    endfunction

    function automatic longint err_of(int s);
        return (s == 1) ? 1 : ((s == 2) ? -1 : 0);
    endfunction

    function automatic longint sat(longint v);
        return (v > AMAX) ? AMAX : ((v < AMIN) ? AMIN : v);
    endfunction

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mr <= '0; mf <= '0; ms <= 0; macc <= 0;
        end else begin
            mr <= {mr[1:0], ref_in};
            mf <= {mf[1:0], fb_in};
            ms <= next_st(ms, mr[1] & ~mr[2], mf[1] & ~mf[2]);
            macc <= acc_clr ? 0 : sat(macc + err_of(ms));
        end
    end

    task automatic chk(bit ok, string req, longint act, longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    function automatic longint err_val(logic [1:0] e);
        return (e == 2'b01) ? 1 : ((e == 2'b11) ? -1 : ((e == 2'b00) ? 0 : 9));
    endfunction

    // Advance one cycle and compare all outputs against the model away from the edge
    task automatic tick();
        @(negedge clk);
        chk(up == (ms == 1 || ms == 3), "R2 up", up, (ms == 1 || ms == 3));
        chk(dn == (ms == 2 || ms == 3), "R3 dn", dn, (ms == 2 || ms == 3));
        chk(err_val(err) == err_of(ms), "R7 err", err_val(err), err_of(ms));
        chk($signed(acc) == macc, "R8 acc", $signed(acc), macc);
    endtask

    task automatic ticks(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    task automatic settle_idle();
        ref_in = 1'b0; fb_in = 1'b0; ticks(6);
        if (up || dn) begin ref_in = 1'b1; fb_in = 1'b1; ticks(4); ref_in = 1'b0; fb_in = 1'b0; ticks(6); end
    endtask

    initial begin
        int both_cnt;
        longint sum;
        void'($urandom(32'd7321));
        repeat (3) @(negedge clk);
        chk(!up && !dn && err == 2'b00 && acc == '0, "R1 in reset", {up, dn, err}, 0);
        rst_n = 1'b1;
        tick();
        chk(!up && !dn && err == 2'b00 && acc == '0, "R1 after release", {up, dn, err}, 0);

        // R2 latency: level first sampled at edge k, up after edge k+2
        ref_in = 1'b1;
        tick(); chk(!up, "R2 not yet (k)", up, 0);
        tick(); chk(!up, "R2 not yet (k+1)", up, 0);
        tick(); chk(up && err == 2'b01, "R2 set after k+2", up, 1);
        // R4 repeated reference edges
        ref_in = 1'b0; ticks(3); ref_in = 1'b1; ticks(4);
        chk(up && !dn, "R4 extra ref edge ignored", {up, dn}, 2'b10);
        // R5 overlap exactly one cycle
        fb_in = 1'b1; both_cnt = 0;
        for (int i = 0; i < 8; i++) begin tick(); if (up && dn) both_cnt++; end
        chk(both_cnt == 1, "R5 overlap length", both_cnt, 1);
        chk(!up && !dn, "R5 cleared", {up, dn}, 0);
        // R11 falling edges and held levels
        ref_in = 1'b0; fb_in = 1'b0; ticks(8);
        chk(!up && !dn && err == 2'b00, "R11 falling ignored", {up, dn}, 0);
        // R3 feedback leads
        fb_in = 1'b1; ticks(3);
        chk(dn && !up && err == 2'b11, "R3 dn set", {up, dn}, 2'b01);
        ref_in = 1'b1; ticks(2); ticks(6);
        settle_idle();
        // R6 simultaneous edges from idle
        ref_in = 1'b1; fb_in = 1'b1; both_cnt = 0;
        for (int i = 0; i < 6; i++) begin tick(); if (up || dn) both_cnt++; end
        chk(both_cnt == 0, "R6 tie sets nothing", both_cnt, 0);
        // R5 edge during overlap cycle is dropped: fb edge then ref edge one cycle after overlap starts
        ref_in = 1'b0; fb_in = 1'b0; ticks(6);
        ref_in = 1'b1; ticks(4);
        fb_in = 1'b1; ref_in = 1'b0; tick(); ref_in = 1'b1; ticks(8);
        chk(!up && !dn, "R5 edge in overlap dropped", {up, dn}, 0);

        // R8 clear priority
        acc_clr = 1'b1; tick(); acc_clr = 1'b0;
        chk(acc == '0, "R8 clear", $signed(acc), 0);

        // R10 ref faster than fb
        ref_in = 1'b0; fb_in = 1'b0; ticks(6);
        acc_clr = 1'b1; tick(); acc_clr = 1'b0;
        for (int i = 0; i < 4000; i++) begin ref_in = (i % 20) < 10; fb_in = (i % 26) < 13; tick(); end
        sum = $signed(acc);
        chk(sum > 0, "R10 ref faster gives positive", sum, 1);
        settle_idle();
        acc_clr = 1'b1; tick(); acc_clr = 1'b0;
        for (int i = 0; i < 4000; i++) begin ref_in = (i % 26) < 13; fb_in = (i % 20) < 10; tick(); end
        sum = $signed(acc);
        chk(sum < 0, "R10 fb faster gives negative", sum, -1);

        // Random toggles with occasional clears
        settle_idle();
        for (int i = 0; i < 6000; i++) begin
            if ($urandom_range(0, 9) == 0) ref_in = ~ref_in;
            if ($urandom_range(0, 9) == 0) fb_in = ~fb_in;
            acc_clr = ($urandom_range(0, 499) == 0);
            tick();
        end
        acc_clr = 1'b0;

        // R9 saturation at both rails
        settle_idle();
        acc_clr = 1'b1; tick(); acc_clr = 1'b0;
        ref_in = 1'b1; ticks(33000);
        chk($signed(acc) == AMAX, "R9 top rail", $signed(acc), AMAX);
        fb_in = 1'b1; ticks(6); fb_in = 1'b0; ticks(4); fb_in = 1'b1; ticks(66000);
        chk($signed(acc) == AMIN, "R9 bottom rail", $signed(acc), AMIN);

        // R1 reset mid-run
        rst_n = 1'b0; @(negedge clk);
        chk(!up && !dn && acc == '0, "R1 reset mid-run", $signed(acc), 0);
        rst_n = 1'b1; ref_in = 1'b0; fb_in = 1'b0; ticks(4);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=running expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule